// File: doc/BRIEF.md
# Accumulator ALU with Decimal Adjust

This block is the 8-bit arithmetic and logic stage that sits behind the accumulator of a small 8-bit CPU. Each cycle it may accept one operation. The inputs are the current accumulator value, a second operand, a 4-bit operation code and the four incoming condition flags (zero, subtract, half-carry, carry). One clock later it returns the new accumulator value, a write strobe for the accumulator and the full set of new flags. Operand fetch, decode and the register file are outside the block.

The supported operations are:
- addition, with and without carry-in;
- subtraction, with and without borrow-in;
- compare;
- AND, XOR and OR;
- rotate-left and rotate-right of the accumulator through carry;
- decimal adjust after a BCD add or subtract.

Compare produces the same flags as subtraction but leaves the accumulator alone. Decimal adjust picks its correction from the incoming subtract, half-carry and carry flags, so it has to follow the instruction it corrects.

Flags are carried as a 4-bit vector: bit 3 = Z, bit 2 = N, bit 1 = H, bit 0 = C.

Top module: `acc_alu`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid`, `acc_we`, `acc_out` and `flags_out` are all zero.
- R2: The result of an operation presented with `in_valid` high appears on the outputs exactly one cycle later, with `out_valid` high. A cycle with `in_valid` low gives `out_valid` = 0 and `acc_we` = 0 on the next cycle.
- R3: SUB (code 2) and SBC (code 3) write A − B − cin to the accumulator with `acc_we` = 1. The carry-in cin is the incoming C flag for SBC and 0 for SUB.
- R4: For SUB, SBC and CP, the flags are set as follows, with cin counted in both borrows:
  - C is set on a borrow out of bit 7.
  - H is set on a borrow out of bit 3.
  - N is 1.
  - Z is set when the 8-bit difference is zero.
- R5: CP (code 7) produces the flags of SUB for the same operands, with `acc_we` = 0 and `acc_out` equal to the incoming A.
- R6: ADD (code 0) and ADC (code 1) write A + B + cin, where cin is C for ADC only. H is the carry out of bit 3, C is the carry out of bit 7, N is 0 and Z is set for a zero sum.
- R7: AND (code 4) writes A & B and sets H = 1, N = 0, C = 0, and Z from the result.
- R8: XOR (code 5) and OR (code 6) write their result and clear N, H and C; Z is set from the result.
- R9: Rotate-left (code 8) moves the old C into bit 0 and bit 7 into C. Rotate-right (code 9) moves the old C into bit 7 and bit 0 into C. Both write A and clear Z, N and H.
- R10: Decimal adjust (code 10) uses a low correction of 0x06 when H is set, or when N is clear and the low nibble of A exceeds 9.
- R11: Decimal adjust adds 0x60 to the correction and sets C when C was set, or when N is clear and A exceeds 0x99. Otherwise it clears C.
- R12: Decimal adjust subtracts the correction from A when N is set and adds it otherwise. It writes A, clears H, keeps N and sets Z from the result.
- R13: Codes 11 to 15 give `acc_we` = 0, `acc_out` equal to A and `flags_out` equal to `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_in | input | 4 | Operation code |
| acc_in | input | 8 | Current accumulator |
| opnd_in | input | 8 | Second operand |
| flags_in | input | 4 | Incoming flags {Z,N,H,C} |
| out_valid | output | 1 | Result present |
| acc_out | output | 8 | New accumulator value |
| acc_we | output | 1 | Write strobe for the accumulator |
| flags_out | output | 4 | New flags {Z,N,H,C} |

## Verification
Directed vectors cover the subtract and add groups at four points:
- equal operands, which give a zero result;
- a nibble borrow or carry without a byte borrow or carry;
- a byte wrap;
- a carry-in that by itself flips the outcome.

Together these separate the H and C sources and the cin handling.

Decimal adjust is tried in four ways:
- with each incoming flag alone;
- with the 0x99 and nibble-9 thresholds from both sides;
- in add mode;
- in subtract mode.

This shows that the correction depends on the prior flags and not on the data alone.

A long pseudo-random stream over all sixteen codes then checks every operation, including the unused codes and compare, against an independent integer model.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int BYTE_W   = 8;
    localparam int NIBBLE_W = BYTE_W / 2;
    localparam int FLAG_W   = 4;

    localparam logic [NIBBLE_W-1:0] DEC_DIGIT_MAX = 4'd9;
    localparam logic [BYTE_W-1:0]   DEC_BYTE_MAX  = 8'h99;
    localparam logic [BYTE_W-1:0]   ADJ_LOW       = 8'h06;
    localparam logic [BYTE_W-1:0]   ADJ_HIGH      = 8'h60;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_AND = 4'd4,
        OP_XOR = 4'd5,
        OP_OR  = 4'd6,
        OP_CP  = 4'd7,
        OP_RLA = 4'd8,
        OP_RRA = 4'd9,
        OP_DAA = 4'd10
    } alu_op_e;

    typedef enum logic [1:0] {
        LK_AND = 2'd0,
        LK_XOR = 2'd1,
        LK_OR  = 2'd2
    } logic_kind_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    function automatic logic is_zero(input logic [BYTE_W-1:0] v);
        return ~|v;
    endfunction

    function automatic logic uses_subtract(input alu_op_e op);
        return (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP);
    endfunction

    function automatic logic takes_carry_in(input alu_op_e op);
        return (op == OP_ADC) || (op == OP_SBC);
    endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              do_sub,
    output logic [DATA_W-1:0] res,
    output logic              half_out,
    output logic              carry_out
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W:0] full_sum;
    logic [HALF_W:0] low_sum;
    logic [DATA_W:0] cin_wide;
    logic [HALF_W:0] cin_low;

    assign cin_wide = {{DATA_W{1'b0}}, cin};
    assign cin_low  = {{HALF_W{1'b0}}, cin};

    always_comb begin
        if (do_sub) begin
            full_sum = {1'b0, a} - {1'b0, b} - cin_wide;
            low_sum  = {1'b0, a[HALF_W-1:0]} - {1'b0, b[HALF_W-1:0]} - cin_low;
        end else begin
            full_sum = {1'b0, a} + {1'b0, b} + cin_wide;
            low_sum  = {1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]} + cin_low;
        end
    end

    assign res       = full_sum[DATA_W-1:0];
    assign carry_out = full_sum[DATA_W];
    assign half_out  = low_sum[HALF_W];

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic_kind_e       kind,
    output logic [DATA_W-1:0] res
);
    always_comb begin
        case (kind)
            LK_AND:  res = a & b;
            LK_XOR:  res = a ^ b;
            LK_OR:   res = a | b;
            default: res = a & b;
        endcase
    end
endmodule

// File: rtl/acc_alu_rotate.sv
module acc_alu_rotate
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic              cin,
    input  logic              to_right,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    logic [DATA_W-1:0] left_res;
    logic [DATA_W-1:0] right_res;

    assign left_res  = {a[DATA_W-2:0], cin};
    assign right_res = {cin, a[DATA_W-1:1]};

    assign res  = to_right ? right_res : left_res;
    assign cout = to_right ? a[0] : a[DATA_W-1];
endmodule

// File: rtl/acc_alu_daa.sv
module acc_alu_daa
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic [DATA_W-1:0] a,
    input  flags_t            fin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam int HALF_W = DATA_W / 2;

    logic              need_low;
    logic              need_high;
    logic [DATA_W-1:0] corr;

    assign need_low  = fin.h || (!fin.n && (a[HALF_W-1:0] > DEC_DIGIT_MAX));
    assign need_high = fin.c || (!fin.n && (a > DEC_BYTE_MAX));

    always_comb begin
        corr = '0;
        if (need_low)  corr = corr | ADJ_LOW;
        if (need_high) corr = corr | ADJ_HIGH;
    end

    assign res  = fin.n ? (a - corr) : (a + corr);
    assign cout = need_high;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        op_in,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] acc_out,
    output logic              acc_we,
    output logic [FLAG_W-1:0] flags_out
);
    alu_op_e op;
    flags_t  fin;

    assign op  = alu_op_e'(op_in);
    assign fin = flags_t'(flags_in);

    // add/subtract path
    logic              as_sub;
    logic              as_cin;
    logic [DATA_W-1:0] as_res;
    logic              as_half;
    logic              as_carry;

    assign as_sub = uses_subtract(op);
    assign as_cin = takes_carry_in(op) ? fin.c : 1'b0;

    acc_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a(acc_in), .b(opnd_in), .cin(as_cin), .do_sub(as_sub),
        .res(as_res), .half_out(as_half), .carry_out(as_carry)
    );

    // bitwise path
    logic_kind_e       lg_kind;
    logic [DATA_W-1:0] lg_res;

    always_comb begin
        case (op)
            OP_XOR:  lg_kind = LK_XOR;
            OP_OR:   lg_kind = LK_OR;
            default: lg_kind = LK_AND;
        endcase
    end

    acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a(acc_in), .b(opnd_in), .kind(lg_kind), .res(lg_res)
    );

    // rotate-through-carry path
    logic [DATA_W-1:0] rt_res;
    logic              rt_cout;

    acc_alu_rotate #(.DATA_W(DATA_W)) u_rotate (
        .a(acc_in), .cin(fin.c), .to_right(op == OP_RRA),
        .res(rt_res), .cout(rt_cout)
    );

    // decimal adjust path
    logic [DATA_W-1:0] da_res;
    logic              da_cout;

    acc_alu_daa #(.DATA_W(DATA_W)) u_daa (
        .a(acc_in), .fin(fin), .res(da_res), .cout(da_cout)
    );

    // result select
    logic [DATA_W-1:0] nxt_acc;
    logic              nxt_we;
    flags_t            nxt_fl;

    always_comb begin
        nxt_acc = acc_in;
        nxt_we  = 1'b0;
        nxt_fl  = fin;
        case (op)
            OP_ADD, OP_ADC: begin
                nxt_acc = as_res;
                nxt_we  = 1'b1;
                nxt_fl  = '{z: is_zero(as_res), n: 1'b0, h: as_half, c: as_carry};
            end
            OP_SUB, OP_SBC: begin
                nxt_acc = as_res;
                nxt_we  = 1'b1;
                nxt_fl  = '{z: is_zero(as_res), n: 1'b1, h: as_half, c: as_carry};
            end
            OP_CP: begin
                nxt_fl  = '{z: is_zero(as_res), n: 1'b1, h: as_half, c: as_carry};
            end
            OP_AND: begin
                nxt_acc = lg_res;
                nxt_we  = 1'b1;
                nxt_fl  = '{z: is_zero(lg_res), n: 1'b0, h: 1'b1, c: 1'b0};
            end
            OP_XOR, OP_OR: begin
                nxt_acc = lg_res;
                nxt_we  = 1'b1;
                nxt_fl  = '{z: is_zero(lg_res), n: 1'b0, h: 1'b0, c: 1'b0};
            end
            OP_RLA, OP_RRA: begin
                nxt_acc = rt_res;
                nxt_we  = 1'b1;
                nxt_fl  = '{z: 1'b0, n: 1'b0, h: 1'b0, c: rt_cout};
            end
            OP_DAA: begin
                nxt_acc = da_res;
                nxt_we  = 1'b1;
                nxt_fl  = '{z: is_zero(da_res), n: fin.n, h: 1'b0, c: da_cout};
            end
            default: ;
        endcase
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            acc_out   <= '0;
            acc_we    <= 1'b0;
            flags_out <= '0;
        end else if (in_valid) begin
            out_valid <= 1'b1;
            acc_out   <= nxt_acc;
            acc_we    <= nxt_we;
            flags_out <= nxt_fl;
        end else begin
            out_valid <= 1'b0;
            acc_we    <= 1'b0;
        end
    end

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!out_valid && !acc_we)); // R2
    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R2
    AST_SUB_N_SET: assert property (@(posedge clk) disable iff (rst) (in_valid && (op_in == 4'd2 || op_in == 4'd3 || op_in == 4'd7)) |=> flags_out[2]); // R4
    AST_CP_NO_WRITE: assert property (@(posedge clk) disable iff (rst) (in_valid && op_in == 4'd7) |=> (!acc_we && acc_out == $past(acc_in))); // R5
    AST_ADD_N_CLEAR: assert property (@(posedge clk) disable iff (rst) (in_valid && op_in <= 4'd1) |=> (!flags_out[2] && acc_we)); // R6
    AST_AND_FLAGS: assert property (@(posedge clk) disable iff (rst) (in_valid && op_in == 4'd4) |=> (flags_out[1] && !flags_out[2] && !flags_out[0])); // R7
    AST_ROT_ZNH_CLEAR: assert property (@(posedge clk) disable iff (rst) (in_valid && (op_in == 4'd8 || op_in == 4'd9)) |=> (flags_out[3:1] == 3'b000 && acc_we)); // R9
    AST_DAA_N_KEPT: assert property (@(posedge clk) disable iff (rst) (in_valid && op_in == 4'd10) |=> (flags_out[2] == $past(flags_in[2]) && !flags_out[1])); // R12
    AST_UNUSED_PASS: assert property (@(posedge clk) disable iff (rst) (in_valid && op_in > 4'd10) |=> (!acc_we && flags_out == $past(flags_in) && acc_out == $past(acc_in))); // R13

endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] op_in = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] opnd_in = '0;
    logic [3:0] flags_in = '0;
    logic       out_valid;
    logic [7:0] acc_out;
    logic       acc_we;
    logic [3:0] flags_out;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        int acc;
        int we;
        int fl;
        int op;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_in(op_in),
        .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
        .out_valid(out_valid), .acc_out(acc_out), .acc_we(acc_we),
        .flags_out(flags_out)
    );

    function automatic string req_of(input int op);
        case (op)
            0, 1:     return "R6";
            2, 3:     return "R3/R4";
            7:        return "R5";
            4:        return "R7";
            5, 6:     return "R8";
            8, 9:     return "R9";
            10:       return "R10/R11/R12";
            default:  return "R13";
        endcase
    endfunction

    // integer reference model written from the requirements
    function automatic void model(input int op, input int a, input int b, input int f,
                                  output int ea, output int ew, output int ef);
        int z, n, h, c, cin, r, lo, corr;
        z = (f >> 3) & 1; n = (f >> 2) & 1; h = (f >> 1) & 1; c = f & 1;
        ea = a; ew = 0;
        case (op)
            0, 1: begin
                cin = (op == 1) ? c : 0;
                r = a + b + cin; lo = (a % 16) + (b % 16) + cin;
                ea = r % 256; ew = 1;
                z = (ea == 0); n = 0; h = (lo > 15); c = (r > 255);
            end
            2, 3, 7: begin
                cin = (op == 3) ? c : 0;
                r = a - b - cin; lo = (a % 16) - (b % 16) - cin;
                z = ((r & 255) == 0); n = 1; h = (lo < 0); c = (r < 0);
                if (op != 7) begin ea = r & 255; ew = 1; end
            end
            4: begin ea = a & b; ew = 1; z = (ea == 0); n = 0; h = 1; c = 0; end
            5: begin ea = a ^ b; ew = 1; z = (ea == 0); n = 0; h = 0; c = 0; end
            6: begin ea = a | b; ew = 1; z = (ea == 0); n = 0; h = 0; c = 0; end
            8: begin ea = ((a << 1) & 255) | c; c = a >> 7; z = 0; n = 0; h = 0; ew = 1; end
            9: begin ea = (a >> 1) | (c << 7); c = a & 1; z = 0; n = 0; h = 0; ew = 1; end
            10: begin
                corr = 0;
                if (h == 1 || (n == 0 && (a % 16) > 9)) corr = 6;
                if (c == 1 || (n == 0 && a > 153)) begin corr = corr + 96; c = 1; end
                else c = 0;
                ea = (n == 1) ? ((a - corr) & 255) : ((a + corr) & 255);
                h = 0; z = (ea == 0); ew = 1;
            end
            default: ;
        endcase
        ef = z * 8 + n * 4 + h * 2 + c;
    endfunction

    task automatic drive(input int op, input int a, input int b, input int f);
        exp_t e;
        @(negedge clk);
        model(op, a, b, f, e.acc, e.we, e.fl);
        e.op = op;
        sb_q.push_back(e);
        op_in = op[3:0]; acc_in = a[7:0]; opnd_in = b[7:0]; flags_in = f[3:0];
        in_valid = 1'b1;
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: compares each result against the scoreboard head
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            tests++;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected result: actual out_valid=1 expected 0");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (int'(acc_out) != e.acc || int'(acc_we) != e.we || int'(flags_out) != e.fl) begin
                    fails++;
                    $display("FAIL %s op=%0d: actual acc=%02h we=%0d fl=%h expected acc=%02h we=%0d fl=%h",
                             req_of(e.op), e.op, acc_out, acc_we, flags_out, e.acc, e.we, e.fl);
                end
            end
        end
    end

    task automatic check_idle(input string what);
        @(negedge clk);
        tests++;
        if (out_valid !== 1'b0 || acc_we !== 1'b0) begin
            fails++;
            $display("FAIL R2 %s: actual valid=%0d we=%0d expected 0 0", what, out_valid, acc_we);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog expired: actual hang expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int unsigned rs;
        repeat (3) @(negedge clk);
        tests++;
        if (out_valid !== 1'b0 || acc_we !== 1'b0 || acc_out !== 8'h00 || flags_out !== 4'h0) begin
            fails++;
            $display("FAIL R1 reset: actual v=%0d we=%0d acc=%02h fl=%h expected all zero",
                     out_valid, acc_we, acc_out, flags_out);
        end
        rst = 1'b0;
        check_idle("after reset R1");

        // R3 R4 subtract group
        drive(2, 8'h3E, 8'h3E, 0);   // zero
        drive(2, 8'h10, 8'h01, 0);   // nibble borrow only
        drive(2, 8'h00, 8'h01, 0);   // byte wrap
        drive(3, 8'h10, 8'h0F, 1);   // borrow-in gives zero
        drive(3, 8'h00, 8'h00, 1);   // borrow-in alone wraps
        drive(3, 8'h55, 8'h11, 0);   // cin clear
        // R5 compare
        drive(7, 8'h42, 8'h50, 0);
        drive(7, 8'h42, 8'h42, 15);
        // R6 add group
        drive(0, 8'h0F, 8'h01, 0);
        drive(0, 8'hFF, 8'h01, 0);
        drive(1, 8'h7F, 8'h80, 1);
        drive(1, 8'h7F, 8'h80, 0);
        // R7 R8 bitwise
        drive(4, 8'hF0, 8'h0F, 1);
        drive(4, 8'hF3, 8'h3F, 0);
        drive(5, 8'hA5, 8'hA5, 15);
        drive(6, 8'h00, 8'h00, 15);
        drive(6, 8'h80, 8'h01, 1);
        // R9 rotates
        drive(8, 8'h80, 8'h00, 0);
        drive(8, 8'h01, 8'h00, 1);
        drive(9, 8'h01, 8'h00, 1);
        drive(9, 8'h02, 8'h00, 8);
        // R10 R11 R12 decimal adjust
        drive(10, 8'h0A, 0, 0);
        drive(10, 8'h09, 0, 0);
        drive(10, 8'h9A, 0, 0);
        drive(10, 8'h99, 0, 0);
        drive(10, 8'h45, 0, 2);
        drive(10, 8'h0F, 0, 6);
        drive(10, 8'h70, 0, 5);
        drive(10, 8'hA0, 0, 4);
        drive(10, 8'h00, 0, 1);
        // R13 unused codes
        drive(11, 8'h12, 8'h34, 15);
        drive(15, 8'h00, 8'hFF, 5);
        go_idle();
        check_idle("gap");
        check_idle("gap2");

        rs = 32'h1234_5678;
        for (int i = 0; i < 600; i++) begin
            rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
            drive(int'(rs[3:0]), int'(rs[11:4]), int'(rs[19:12]), int'(rs[23:20]));
            if (rs[31:28] == 4'd0) go_idle();
        end
        go_idle();
        repeat (3) @(negedge clk);
        tests++;
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL R2 missing results: actual %0d pending expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule